// File: doc/BRIEF.md
# Write-Back Data Cache Controller with No-Fill Disable Mode

This block is a small direct-mapped, write-back data cache that sits between a CPU load/store port and a main-memory port. It keeps a five-state coherence code per line, answers coherence probes from another agent, and can walk the whole array to write back and invalidate every line on command. A control word carries a cache-off bit at position 30. While that bit is set, the cache stops allocating: every CPU access becomes a single-word uncached memory transaction, and a line that the access hits is first written back (when dirty) and then dropped, so memory always holds the only copy being used.

The controller is one state machine. `F_IDLE` picks work in the order probe, flush, CPU. A CPU request goes `F_IDLE -> F_LOOK`. From `F_LOOK`: enabled hit `-> F_HIT`; enabled miss with a clean or empty victim `-> F_FILL`; enabled miss with a dirty victim `-> F_WB -> F_FILL`; `F_FILL -> F_HIT`; `F_HIT -> F_DONE`. With the cache off: dirty hit `-> F_WB -> F_INV`; clean hit `-> F_INV`; miss `-> F_UNC`; `F_INV -> F_UNC -> F_DONE`. `F_DONE -> F_IDLE`. A probe goes `F_IDLE -> F_PLOOK`, then `-> F_WB -> F_PEND` on a dirty hit or straight to `F_PEND`, then `-> F_IDLE`. A flush goes `F_IDLE -> F_FCHK`, `-> F_WB -> F_FNXT` for a dirty line or straight to `F_FNXT`, then back to `F_FCHK` for the next index or to `F_IDLE` after the last one. `F_WB` returns to whichever state was recorded when it was entered.

Top module: `wb_cache_ctl`

## Requirements
- R1: After reset every line is invalid (code I=0), no reply strobe or memory request is active, and the first access to every line misses.
- R2: With caching on (control bit 30 clear), a read miss fills the whole line with 4 cacheable reads and leaves it Exclusive (E=2); a repeat read to that line makes no memory transaction and returns the same word.
- R3: With caching on, a write hit makes the line Modified (M=4) with no memory traffic; a miss whose victim is Modified or Owned (O=3) first writes the 4 victim words back, then fills.
- R4: With caching off (control bit 30 set), a miss makes exactly one uncached transaction and allocates nothing, so a later access to the same address misses again.
- R5: With caching off, a hit on a Modified or Owned line writes the 4 words back, invalidates the line and then makes one uncached transaction for the requested word.
- R6: With caching off, a hit on a clean line (S=1 or E=2) invalidates it and makes one uncached transaction with no write-back.
- R7: A probe that hits a Modified or Owned line writes it back; a shared-read probe (kind 0) leaves a hit line valid and clean (Shared), so a later CPU read hits.
- R8: A probe of kind 1 (exclusive read), 2 or 3 (write) that hits invalidates the line, after a write-back if it was dirty.
- R9: A probe that misses reports no hit and makes no memory transaction.
- R10: A flush writes back every dirty line in ascending index order, leaves every line invalid, pulses the done output once, and works with caching on or off.
- R11: Control bit 29 has no effect on the operating mode selected by bit 30.
- R12: When a probe and a CPU request are both pending while idle, the probe is answered first.
- R13: Uncached transactions carry the uncached attribute and move one word; write-backs and fills carry the cacheable attribute and move 4 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_word | input | 32 | Control word; bit 30 turns caching off, bit 29 is ignored |
| cpu_valid | input | 1 | CPU request, held until cpu_ready |
| cpu_we | input | 1 | CPU write when 1, read when 0 |
| cpu_addr | input | 32 | CPU byte address, word aligned |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion of the CPU request |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| prb_valid | input | 1 | Probe request, held until prb_done |
| prb_kind | input | 2 | 0 shared read, 1 exclusive read, 2 or 3 write |
| prb_addr | input | 32 | Probe byte address |
| prb_done | output | 1 | One-cycle completion of the probe |
| prb_hit | output | 1 | Probe found the line, valid with prb_done |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle pulse after the last line is handled |
| mem_req | output | 1 | Memory beat request, held until mem_ack |
| mem_we | output | 1 | Memory write beat |
| mem_cacheable | output | 1 | 1 for line transfers, 0 for uncached accesses |
| mem_addr | output | 32 | Memory byte address of the beat |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Beat completes |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is a probe and a CPU request arriving in the same idle cycle on the same dirty line, where the probe must win, write the line back and invalidate it, so the CPU access must then refill with fresh data. The bench drives both requests on the same falling edge, records which completion strobe rises first, and predicts the combined number of memory beats from its own model of line tags and dirty bits. The cache-off hit on a dirty line is reached by first dirtying every line with caching on, then setting bit 30 and reading those lines back, counting write-back and uncached beats separately.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;

    typedef enum logic [2:0] {
        LS_I = 3'd0,
        LS_S = 3'd1,
        LS_E = 3'd2,
        LS_O = 3'd3,
        LS_M = 3'd4
    } line_st_t;

    localparam logic [1:0] PK_SHARED = 2'd0;

    typedef enum logic [3:0] {
        F_IDLE,
        F_LOOK,
        F_WB,
        F_FILL,
        F_INV,
        F_UNC,
        F_HIT,
        F_DONE,
        F_PLOOK,
        F_PEND,
        F_FCHK,
        F_FNXT
    } fsm_t;

endpackage

// File: rtl/wb_line_store.sv
module wb_line_store
    import wb_cache_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int TAGW  = 24,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    input  logic [$clog2(WORDS)-1:0] wsel,
    output logic [TAGW-1:0]          rd_tag,
    output line_st_t                 rd_st,
    output logic [DW-1:0]            rd_word,
    output logic                     any_valid,
    input  logic                     st_we,
    input  line_st_t                 st_val,
    input  logic                     tag_we,
    input  logic [TAGW-1:0]          tag_val,
    input  logic                     dat_we,
    input  logic [DW-1:0]            dat_val
);
    localparam int IDXW = $clog2(LINES);

    logic [TAGW-1:0] tags [LINES];
    line_st_t        sts  [LINES];
    logic [DW-1:0]   data [LINES][WORDS];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sts[g] <= LS_I;
            else if (st_we && idx == IDXW'(g))
                sts[g] <= st_val;
        end

        always_ff @(posedge clk) begin
            if (tag_we && idx == IDXW'(g))
                tags[g] <= tag_val;
            if (dat_we && idx == IDXW'(g))
                data[g][wsel] <= dat_val;
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < LINES; i++)
            any_valid = any_valid | (sts[i] != LS_I);
    end

    assign rd_tag  = tags[idx];
    assign rd_st   = sts[idx];
    assign rd_word = data[idx][wsel];

endmodule

// File: rtl/wb_cache_ctl.sv
module wb_cache_ctl
    import wb_cache_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int LINES   = 16,
    parameter int WORDS   = 4,
    parameter int CTLW    = 32,
    parameter int DIS_BIT = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CTLW-1:0] ctl_word,
    input  logic            cpu_valid,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_ready,
    output logic [DW-1:0]   cpu_rdata,
    input  logic            prb_valid,
    input  logic [1:0]      prb_kind,
    input  logic [AW-1:0]   prb_addr,
    output logic            prb_done,
    output logic            prb_hit,
    input  logic            flush_req,
    output logic            flush_done,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_cacheable,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int OFFW = $clog2(WORDS);
    localparam int IDXW = $clog2(LINES);
    localparam int TAGW = AW - IDXW - OFFW - 2;
    localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(LINES - 1);
    localparam logic [OFFW-1:0] LAST_BEAT = OFFW'(WORDS - 1);

    fsm_t            fsm, ret;
    logic [AW-1:0]   r_addr;
    logic            r_we, r_dis;
    logic [DW-1:0]   r_wdata, rdata_q;
    logic [1:0]      r_pkind;
    logic [OFFW-1:0] beat;
    logic [IDXW-1:0] cur_idx;
    logic            phit_q;

    logic [TAGW-1:0] rd_tag;
    line_st_t        rd_st;
    logic [DW-1:0]   rd_word;
    logic            any_valid;
    logic            st_we, tag_we, dat_we;
    line_st_t        st_val;
    logic [OFFW-1:0] wsel;
    logic [DW-1:0]   dat_val;
    logic            hit, dirty;
    logic            ctl_unused;

    assign ctl_unused = ^ctl_word;

    wire [TAGW-1:0] r_tag  = r_addr[AW-1 -: TAGW];
    wire [OFFW-1:0] r_word = r_addr[2 +: OFFW];

    assign hit   = (rd_st != LS_I) && (rd_tag == r_tag);
    assign dirty = (rd_st == LS_M) || (rd_st == LS_O);

    wb_line_store #(.LINES(LINES), .WORDS(WORDS), .TAGW(TAGW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(cur_idx), .wsel(wsel),
        .rd_tag(rd_tag), .rd_st(rd_st), .rd_word(rd_word), .any_valid(any_valid),
        .st_we(st_we), .st_val(st_val), .tag_we(tag_we), .tag_val(r_tag),
        .dat_we(dat_we), .dat_val(dat_val)
    );

    // State register and per-transaction bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm     <= F_IDLE;
            ret     <= F_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_dis   <= 1'b0;
            r_wdata <= '0;
            rdata_q <= '0;
            r_pkind <= '0;
            beat    <= '0;
            cur_idx <= '0;
            phit_q  <= 1'b0;
        end else begin
            unique case (fsm)
                F_IDLE: begin
                    beat <= '0;
                    if (prb_valid) begin
                        r_addr  <= prb_addr;
                        r_pkind <= prb_kind;
                        cur_idx <= prb_addr[2+OFFW +: IDXW];
                        fsm     <= F_PLOOK;
                    end else if (flush_req) begin
                        cur_idx <= '0;
                        fsm     <= F_FCHK;
                    end else if (cpu_valid) begin
                        r_addr  <= cpu_addr;
                        r_we    <= cpu_we;
                        r_wdata <= cpu_wdata;
                        r_dis   <= ctl_word[DIS_BIT];
                        cur_idx <= cpu_addr[2+OFFW +: IDXW];
                        fsm     <= F_LOOK;
                    end
                end
                F_LOOK: begin
                    if (r_dis) begin
                        if (hit && dirty) begin
                            ret <= F_INV;
                            fsm <= F_WB;
                        end else if (hit) fsm <= F_INV;
                        else              fsm <= F_UNC;
                    end else if (hit) begin
                        fsm <= F_HIT;
                    end else if (dirty) begin
                        ret <= F_FILL;
                        fsm <= F_WB;
                    end else begin
                        fsm <= F_FILL;
                    end
                end
                F_WB: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST_BEAT) fsm <= ret;
                end
                F_FILL: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST_BEAT) fsm <= F_HIT;
                end
                F_HIT: begin
                    if (!r_we) rdata_q <= rd_word;
                    fsm <= F_DONE;
                end
                F_INV: fsm <= F_UNC;
                F_UNC: if (mem_ack) begin
                    if (!r_we) rdata_q <= mem_rdata;
                    fsm <= F_DONE;
                end
                F_DONE: fsm <= F_IDLE;
                F_PLOOK: begin
                    phit_q <= hit;
                    if (hit && dirty) begin
                        ret <= F_PEND;
                        fsm <= F_WB;
                    end else fsm <= F_PEND;
                end
                F_PEND: fsm <= F_IDLE;
                F_FCHK: begin
                    beat <= '0;
                    if (dirty) begin
                        ret <= F_FNXT;
                        fsm <= F_WB;
                    end else fsm <= F_FNXT;
                end
                F_FNXT: begin
                    if (cur_idx == LAST_IDX) fsm <= F_IDLE;
                    else begin
                        cur_idx <= cur_idx + 1'b1;
                        fsm     <= F_FCHK;
                    end
                end
                default: fsm <= F_IDLE;
            endcase
        end
    end

    // Outputs: memory port, array writes, reply strobes
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_cacheable = 1'b1;
        mem_addr      = '0;
        mem_wdata     = '0;
        st_we         = 1'b0;
        st_val        = LS_I;
        tag_we        = 1'b0;
        dat_we        = 1'b0;
        dat_val       = r_wdata;
        wsel          = r_word;
        unique case (fsm)
            F_WB: begin
                wsel      = beat;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, cur_idx, beat, 2'b00};
                mem_wdata = rd_word;
            end
            F_FILL: begin
                wsel     = beat;
                mem_req  = 1'b1;
                mem_addr = {r_tag, cur_idx, beat, 2'b00};
                dat_we   = mem_ack;
                dat_val  = mem_rdata;
                if (mem_ack && beat == LAST_BEAT) begin
                    tag_we = 1'b1;
                    st_we  = 1'b1;
                    st_val = LS_E;
                end
            end
            F_HIT: if (r_we) begin
                dat_we = 1'b1;
                st_we  = 1'b1;
                st_val = LS_M;
            end
            F_INV, F_FNXT: st_we = 1'b1;
            F_UNC: begin
                mem_req       = 1'b1;
                mem_we        = r_we;
                mem_cacheable = 1'b0;
                mem_addr      = r_addr;
                mem_wdata     = r_wdata;
            end
            F_PEND: if (phit_q) begin
                st_we  = 1'b1;
                st_val = (r_pkind == PK_SHARED) ? LS_S : LS_I;
            end
            default: ;
        endcase
    end

    assign cpu_ready  = (fsm == F_DONE);
    assign cpu_rdata  = rdata_q;
    assign prb_done   = (fsm == F_PEND);
    assign prb_hit    = phit_q;
    assign flush_done = (fsm == F_FNXT) && (cur_idx == LAST_IDX);

    // R4: a request latched with caching off never fills a line
    a_r4_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_cacheable && !mem_we) |-> !r_dis);

    // R13: an uncached transaction is a single beat
    a_r13_unc_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_cacheable) |=> !mem_req);

    // R5: during an uncached access the cache holds no copy of the address
    a_r5_no_stale_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_cacheable) |-> !hit);

    // R10: after the flush pulse no line is valid
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !any_valid);

    // R12: at most one reply strobe per cycle
    a_r12_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_ready, prb_done, flush_done}));

    // R9: a probe miss makes no memory request
    a_r9_probe_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == F_PLOOK && !hit) |=> !mem_req);

endmodule

// File: tb/sim_wb_cache_ctl.sv
`timescale 1ns/1ps
module sim_wb_cache_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctl_word = '0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        prb_valid = 1'b0;
    logic [1:0]  prb_kind = '0;
    logic [31:0] prb_addr = '0;
    logic        prb_done, prb_hit;
    logic        flush_req = 1'b0;
    logic        flush_done;
    logic        mem_req, mem_we, mem_cacheable;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wb_cache_ctl u0 (.*);

    logic [31:0] mem    [1024];
    logic [31:0] refmem [1024];
    int  m_tag [16];
    bit  m_vld [16];
    bit  m_dty [16];
    int  nchk = 0, nerr = 0;
    int  beats = 0, ubeats = 0, ord_err = 0, last_fidx = -1;
    bit  flushing = 1'b0;

    // Memory responder: one beat every two cycles
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        end else mem_ack <= 1'b0;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            beats = beats + 1;
            if (!mem_cacheable) ubeats = ubeats + 1;
            if (flushing && mem_we && mem_cacheable) begin
                if (int'(mem_addr[7:4]) < last_fidx) ord_err = ord_err + 1;
                last_fidx = int'(mem_addr[7:4]);
            end
        end
    end

    function automatic logic [31:0] mk(int tag, int idx, int w);
        return {20'd0, tag[3:0], idx[3:0], w[1:0], 2'b00};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(bit we, int tag, int idx, int w, logic [31:0] wd, string req);
        int eb, eu, b0, u0c;
        bit dis, h;
        logic [31:0] a, rd;
        dis = ctl_word[30];
        a = mk(tag, idx, w);
        h = m_vld[idx] && m_tag[idx] == tag;
        if (dis) begin
            eu = 1;
            eb = (h && m_dty[idx]) ? 5 : 1;
            if (h) begin m_vld[idx] = 0; m_dty[idx] = 0; end
        end else begin
            eu = 0;
            eb = h ? 0 : ((m_vld[idx] && m_dty[idx]) ? 8 : 4);
            if (!h) begin m_vld[idx] = 1; m_tag[idx] = tag; m_dty[idx] = 0; end
            if (we) m_dty[idx] = 1;
        end
        b0 = beats; u0c = ubeats;
        @(negedge clk);
        cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
        end
        rd = cpu_rdata;
        cpu_valid = 0;
        chk(beats - b0 == eb, req, beats - b0, eb);
        chk(ubeats - u0c == eu, req, ubeats - u0c, eu);
        if (we) refmem[a[11:2]] = wd;
        else chk(rd === refmem[a[11:2]], req, rd, refmem[a[11:2]]);
    endtask

    task automatic prb_op(int kind, int tag, int idx, string req);
        int eb, b0;
        bit h;
        h = m_vld[idx] && m_tag[idx] == tag;
        eb = (h && m_dty[idx]) ? 4 : 0;
        if (h) begin
            m_dty[idx] = 0;
            if (kind != 0) m_vld[idx] = 0;
        end
        b0 = beats;
        @(negedge clk);
        prb_valid = 1; prb_kind = kind[1:0]; prb_addr = mk(tag, idx, 0);
        forever begin
            @(negedge clk);
            if (prb_done) break;
        end
        chk(prb_hit == h, req, prb_hit, h);
        prb_valid = 0;
        chk(beats - b0 == eb, req, beats - b0, eb);
    endtask

    task automatic flush_op(string req);
        int eb, b0;
        eb = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_vld[i] && m_dty[i]) eb += 4;
            m_vld[i] = 0; m_dty[i] = 0;
        end
        b0 = beats; ord_err = 0; last_fidx = -1; flushing = 1;
        @(negedge clk);
        flush_req = 1;
        forever begin
            @(negedge clk);
            if (flush_done) break;
        end
        flush_req = 0;
        flushing = 0;
        chk(beats - b0 == eb, req, beats - b0, eb);
        chk(ord_err == 0, req, ord_err, 0);
        @(negedge clk);
        chk(flush_done == 0, req, flush_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        bit pfirst, pseen, cseen;
        int b0;
        logic [31:0] rd;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (i * 32'h01010101) ^ 32'h5A000000;
            refmem[i] = mem[i];
        end
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_dty[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(cpu_ready == 0 && prb_done == 0 && flush_done == 0, "R1", {cpu_ready, prb_done, flush_done}, 0);
        chk(mem_req == 0, "R1", mem_req, 0);

        // R1/R2: every line misses first, then hits
        for (int i = 0; i < 16; i++) cpu_op(0, 1, i, i % 4, 0, "R2");
        for (int i = 0; i < 16; i++) cpu_op(0, 1, i, (i + 1) % 4, 0, "R2");
        // R3: write hits dirty lines with no traffic
        for (int i = 0; i < 16; i++) cpu_op(1, 1, i, 0, 32'hC0DE0000 + i, "R3");
        // R3: dirty victim eviction
        cpu_op(0, 2, 3, 1, 0, "R3");
        chk(mem[mk(1, 3, 0) >> 2] == 32'hC0DE0003, "R3", mem[mk(1, 3, 0) >> 2], 32'hC0DE0003);

        // R7/R8/R9: probes
        prb_op(0, 1, 5, "R7");
        cpu_op(0, 1, 5, 0, 0, "R7");
        prb_op(1, 1, 6, "R8");
        prb_op(2, 1, 7, "R8");
        cpu_op(0, 1, 6, 2, 0, "R8");
        prb_op(3, 1, 6, "R8");
        cpu_op(0, 1, 7, 0, 0, "R8");
        prb_op(0, 3, 8, "R9");
        prb_op(1, 3, 9, "R9");

        // R12: probe and CPU request in the same idle cycle
        begin
            int eb;
            eb = m_dty[0] ? 4 : 0;
            m_dty[0] = 0; m_vld[0] = 0;
            eb += 4; m_vld[0] = 1; m_tag[0] = 1;
            b0 = beats; pfirst = 0; pseen = 0; cseen = 0;
            @(negedge clk);
            prb_valid = 1; prb_kind = 2'd1; prb_addr = mk(1, 0, 0);
            cpu_valid = 1; cpu_we = 0; cpu_addr = mk(1, 0, 0);
            while (!(pseen && cseen)) begin
                @(negedge clk);
                if (prb_done) begin pfirst = !cseen; pseen = 1; prb_valid = 0; end
                if (cpu_ready) begin cseen = 1; rd = cpu_rdata; cpu_valid = 0; end
            end
            chk(pfirst, "R12", pfirst, 1);
            chk(beats - b0 == eb, "R12", beats - b0, eb);
            chk(rd === refmem[mk(1, 0, 0) >> 2], "R12", rd, refmem[mk(1, 0, 0) >> 2]);
        end

        // R11: bit 29 alone keeps caching on
        ctl_word = 32'h2000_0000;
        cpu_op(0, 1, 1, 0, 0, "R11");
        cpu_op(1, 1, 2, 1, 32'hBEEF0002, "R11");

        // Caching off
        ctl_word = 32'h4000_0000;
        cpu_op(0, 1, 10, 1, 0, "R5");
        chk(mem[mk(1, 10, 0) >> 2] == 32'hC0DE000A, "R5", mem[mk(1, 10, 0) >> 2], 32'hC0DE000A);
        cpu_op(0, 1, 10, 1, 0, "R4");
        cpu_op(0, 1, 5, 0, 0, "R6");
        cpu_op(1, 1, 11, 2, 32'h0BAD0011, "R5");
        chk(mem[mk(1, 11, 2) >> 2] == 32'h0BAD0011, "R5", mem[mk(1, 11, 2) >> 2], 32'h0BAD0011);
        chk(mem[mk(1, 11, 0) >> 2] == 32'hC0DE000B, "R5", mem[mk(1, 11, 0) >> 2], 32'hC0DE000B);
        cpu_op(1, 3, 12, 3, 32'h77770012, "R4");
        cpu_op(0, 3, 12, 3, 0, "R4");
        ctl_word = 32'h6000_0000;
        cpu_op(0, 2, 13, 0, 0, "R11");
        cpu_op(0, 1, 2, 1, 0, "R13");

        // R10: flush with caching off, then everything misses
        flush_op("R10");
        ctl_word = 32'h0;
        for (int i = 0; i < 16; i++) cpu_op(0, 1, i, 3, 0, "R10");
        for (int i = 0; i < 16; i += 2) cpu_op(1, 2, i, i % 4, 32'hF00D0000 + i, "R3");
        flush_op("R10");
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== refmem[i]) bad++;
            chk(bad == 0, "R10", bad, 0);
        end
        cpu_op(0, 2, 4, 0, 0, "R13");

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule